// File: doc/BRIEF.md
# Exception Vector Entry Controller

This block works out every architectural state change made when a 64-bit processor takes an exception into a target exception level. A one-cycle take strobe arrives with the current and target levels, the execution state of the interrupted code, the stack-pointer select bit, the exception class, the syndrome and fault address, and the current program counter and processor status. One cycle later the block issues a single-cycle burst of register writes and the redirected program counter.

The vector address is the target level's vector base plus two offsets added together. The first is a group offset, picked by whether the level rises and, if so, which execution state is left, or else by the stack-pointer select. The second is a per-kind offset for synchronous, IRQ and FIQ entry. Class rules decide whether the syndrome and fault-address registers are written. The link and saved-status registers are always written. A class code the block does not support raises an error pulse and writes nothing.

Top module: `ee_entry_ctrl`

## Requirements
- R1: When the target level is above the current level, the group offset is 0x400 if `src64_i` is 1 and 0x600 if `src64_i` is 0.
- R2: When the target level is not above the current level, the group offset is 0x200 if `sp_sel_i` is 1 and 0x000 if it is 0.
- R3: `pc_o` is the vector base of the target level (bits `[64*L+63:64*L]` of `vbar_i` for level L) plus the group offset plus a kind offset. The kind offset is 0x000 for classes 0 to 7, 0x080 for IRQ (8) and virtual IRQ (9), and 0x100 for FIQ (10) and virtual FIQ (11).
- R4: Prefetch abort (class 0) and data abort (class 1) write both the fault-address register (`fault_o` = `fault_addr_i`) and the syndrome register.
- R5: Breakpoint (2), undefined instruction (3), supervisor call (4), hypervisor call (5), hypervisor trap (6) and secure-monitor call (7) write the syndrome register only.
- R6: Interrupt classes 8 to 11 write neither the syndrome register nor the fault-address register.
- R7: For every supported class, the saved-status register is written with `status_i` and the link register with `pc_i`, and `lvl_o` gives the target level.
- R8: The written syndrome equals `syndrome_i`, except that bit 25 is forced to 1 when `src64_i` is 0 and `thumb_i` is 0.
- R9: The new status `status_o` has bits 9:6 set (all four interrupt masks), bits 3:2 equal to the target level, bit 0 set (dedicated stack pointer), and all other bits 0.
- R10: Class codes 12 to 15 give a one-cycle `err_o` pulse with every write enable low, and `pc_o` keeps its previous value.
- R11: All outputs are registered. Write enables pulse high for exactly the one cycle after the clock edge that samples `take_i` high, and stay low when `take_i` is low.
- R12: During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | Exception-take strobe |
| vbar_i | input | 256 | Vector base per level, level L in bits 64L+63:64L |
| cur_lvl_i | input | 2 | Current exception level |
| tgt_lvl_i | input | 2 | Target exception level |
| src64_i | input | 1 | Interrupted code runs in 64-bit state |
| sp_sel_i | input | 1 | Dedicated stack pointer selected |
| thumb_i | input | 1 | Interrupted 32-bit code in Thumb mode |
| exc_class_i | input | 4 | Exception class code |
| syndrome_i | input | 32 | Syndrome value |
| fault_addr_i | input | 64 | Faulting virtual address |
| pc_i | input | 64 | Current program counter |
| status_i | input | 32 | Current processor status |
| pc_we_o | output | 1 | Program counter redirect strobe |
| pc_o | output | 64 | New program counter |
| lvl_o | output | 2 | Level whose registers are written |
| link_we_o | output | 1 | Link register write enable |
| link_o | output | 64 | Link register data |
| sav_we_o | output | 1 | Saved-status write enable |
| sav_o | output | 32 | Saved-status data |
| synd_we_o | output | 1 | Syndrome register write enable |
| synd_o | output | 32 | Syndrome data |
| fault_we_o | output | 1 | Fault-address register write enable |
| fault_o | output | 64 | Fault-address data |
| status_o | output | 32 | New processor status |
| err_o | output | 1 | Unsupported class pulse |

## Verification
The hardest case to reach is bit 25 of the syndrome. It can only appear when a level rise leaves 32-bit, non-Thumb code and the class also writes the syndrome, and in that same path the 0x600 group offset is used. The bench reaches it by pairing an undefined-instruction and a data-abort take from 32-bit code with Thumb both clear and set. The input syndrome keeps bit 25 clear, so a set bit can only come from the block. It then follows with an IRQ from the same state to confirm that no syndrome write leaks through.

// File: rtl/ee_entry_pkg.sv
package ee_entry_pkg;

    typedef enum logic [1:0] {
        KIND_SYNC = 2'd0,
        KIND_IRQ  = 2'd1,
        KIND_FIQ  = 2'd2
    } vec_kind_e;

    typedef struct packed {
        logic      valid;
        logic      wr_synd;
        logic      wr_fault;
        vec_kind_e kind;
    } cls_attr_t;

    localparam logic [11:0] GRP_UP_64   = 12'h400;
    localparam logic [11:0] GRP_UP_32   = 12'h600;
    localparam logic [11:0] GRP_SAME_SP = 12'h200;
    localparam logic [11:0] GRP_SAME_0  = 12'h000;
    localparam logic [11:0] OFF_SYNC    = 12'h000;
    localparam logic [11:0] OFF_IRQ     = 12'h080;
    localparam logic [11:0] OFF_FIQ     = 12'h100;

    localparam int SYND_A32_BIT = 25;
    localparam int ST_MASK_LO   = 6;
    localparam int ST_MASK_W    = 4;
    localparam int ST_LVL_LO    = 2;

endpackage

// File: rtl/ee_class_dec.sv
module ee_class_dec
    import ee_entry_pkg::*;
#(
    parameter int CLS_W = 4
) (
    input  logic [CLS_W-1:0] cls_i,
    output cls_attr_t        attr_o
);
    always_comb begin
        attr_o = '{valid: 1'b0, wr_synd: 1'b0, wr_fault: 1'b0, kind: KIND_SYNC};
        case (cls_i)
            CLS_W'(0), CLS_W'(1): begin
                attr_o.valid    = 1'b1;
                attr_o.wr_synd  = 1'b1;
                attr_o.wr_fault = 1'b1;
            end
            CLS_W'(2), CLS_W'(3), CLS_W'(4), CLS_W'(5), CLS_W'(6), CLS_W'(7): begin
                attr_o.valid   = 1'b1;
                attr_o.wr_synd = 1'b1;
            end
            CLS_W'(8), CLS_W'(9): begin
                attr_o.valid = 1'b1;
                attr_o.kind  = KIND_IRQ;
            end
            CLS_W'(10), CLS_W'(11): begin
                attr_o.valid = 1'b1;
                attr_o.kind  = KIND_FIQ;
            end
            default: attr_o.valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/ee_vec_offset.sv
module ee_vec_offset
    import ee_entry_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LVL_W  = 2
) (
    input  logic [LVL_W-1:0]  cur_lvl_i,
    input  logic [LVL_W-1:0]  tgt_lvl_i,
    input  logic              src64_i,
    input  logic              sp_sel_i,
    input  vec_kind_e         kind_i,
    output logic [ADDR_W-1:0] off_o
);
    logic [11:0] grp;
    logic [11:0] kof;

    always_comb begin
        if (tgt_lvl_i > cur_lvl_i) begin
            grp = src64_i ? GRP_UP_64 : GRP_UP_32;
        end else begin
            grp = sp_sel_i ? GRP_SAME_SP : GRP_SAME_0;
        end
        case (kind_i)
            KIND_IRQ: kof = OFF_IRQ;
            KIND_FIQ: kof = OFF_FIQ;
            default:  kof = OFF_SYNC;
        endcase
        off_o = ADDR_W'(grp) + ADDR_W'(kof);
    end
endmodule

// File: rtl/ee_status_gen.sv
module ee_status_gen
    import ee_entry_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int LVL_W  = 2
) (
    input  logic [LVL_W-1:0]  tgt_lvl_i,
    output logic [STAT_W-1:0] status_o
);
    always_comb begin
        status_o = '0;
        status_o[ST_MASK_LO +: ST_MASK_W] = '1;
        status_o[ST_LVL_LO +: LVL_W]      = tgt_lvl_i;
        status_o[0]                       = 1'b1;
    end
endmodule

// File: rtl/ee_entry_ctrl.sv
module ee_entry_ctrl
    import ee_entry_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int NUM_LVL = 4,
    parameter int SYND_W  = 32,
    parameter int STAT_W  = 32,
    parameter int CLS_W   = 4,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      take_i,
    input  logic [NUM_LVL*ADDR_W-1:0] vbar_i,
    input  logic [LVL_W-1:0]          cur_lvl_i,
    input  logic [LVL_W-1:0]          tgt_lvl_i,
    input  logic                      src64_i,
    input  logic                      sp_sel_i,
    input  logic                      thumb_i,
    input  logic [CLS_W-1:0]          exc_class_i,
    input  logic [SYND_W-1:0]         syndrome_i,
    input  logic [ADDR_W-1:0]         fault_addr_i,
    input  logic [ADDR_W-1:0]         pc_i,
    input  logic [STAT_W-1:0]         status_i,
    output logic                      pc_we_o,
    output logic [ADDR_W-1:0]         pc_o,
    output logic [LVL_W-1:0]          lvl_o,
    output logic                      link_we_o,
    output logic [ADDR_W-1:0]         link_o,
    output logic                      sav_we_o,
    output logic [STAT_W-1:0]         sav_o,
    output logic                      synd_we_o,
    output logic [SYND_W-1:0]         synd_o,
    output logic                      fault_we_o,
    output logic [ADDR_W-1:0]         fault_o,
    output logic [STAT_W-1:0]         status_o,
    output logic                      err_o
);
    typedef struct packed {
        logic              pc_we;
        logic [ADDR_W-1:0] pc;
        logic [LVL_W-1:0]  lvl;
        logic              link_we;
        logic [ADDR_W-1:0] link;
        logic              sav_we;
        logic [STAT_W-1:0] sav;
        logic              synd_we;
        logic [SYND_W-1:0] synd;
        logic              fault_we;
        logic [ADDR_W-1:0] fault;
        logic [STAT_W-1:0] status;
        logic              err;
    } entry_st_t;

    entry_st_t state_d, state_q;

    logic [ADDR_W-1:0] vbar_a [NUM_LVL];
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_vbar
        assign vbar_a[g] = vbar_i[g*ADDR_W +: ADDR_W];
    end

    cls_attr_t         attr;
    logic [ADDR_W-1:0] vec_off;
    logic [STAT_W-1:0] new_status;

    ee_class_dec #(.CLS_W(CLS_W)) u_dec (
        .cls_i  (exc_class_i),
        .attr_o (attr)
    );

    ee_vec_offset #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_off (
        .cur_lvl_i (cur_lvl_i),
        .tgt_lvl_i (tgt_lvl_i),
        .src64_i   (src64_i),
        .sp_sel_i  (sp_sel_i),
        .kind_i    (attr.kind),
        .off_o     (vec_off)
    );

    ee_status_gen #(.STAT_W(STAT_W), .LVL_W(LVL_W)) u_st (
        .tgt_lvl_i (tgt_lvl_i),
        .status_o  (new_status)
    );

    always_comb begin
        state_d          = state_q;
        state_d.pc_we    = 1'b0;
        state_d.link_we  = 1'b0;
        state_d.sav_we   = 1'b0;
        state_d.synd_we  = 1'b0;
        state_d.fault_we = 1'b0;
        state_d.err      = 1'b0;
        if (take_i) begin
            if (!attr.valid) begin
                state_d.err = 1'b1;
            end else begin
                state_d.pc_we   = 1'b1;
                state_d.pc      = vbar_a[tgt_lvl_i] + vec_off;
                state_d.lvl     = tgt_lvl_i;
                state_d.link_we = 1'b1;
                state_d.link    = pc_i;
                state_d.sav_we  = 1'b1;
                state_d.sav     = status_i;
                state_d.status  = new_status;
                if (attr.wr_synd) begin
                    state_d.synd_we = 1'b1;
                    state_d.synd    = syndrome_i;
                    if (!src64_i && !thumb_i) begin
                        state_d.synd[SYND_A32_BIT] = 1'b1;
                    end
                end
                if (attr.wr_fault) begin
                    state_d.fault_we = 1'b1;
                    state_d.fault    = fault_addr_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pc_we_o    = state_q.pc_we;
    assign pc_o       = state_q.pc;
    assign lvl_o      = state_q.lvl;
    assign link_we_o  = state_q.link_we;
    assign link_o     = state_q.link;
    assign sav_we_o   = state_q.sav_we;
    assign sav_o      = state_q.sav;
    assign synd_we_o  = state_q.synd_we;
    assign synd_o     = state_q.synd;
    assign fault_we_o = state_q.fault_we;
    assign fault_o    = state_q.fault;
    assign status_o   = state_q.status;
    assign err_o      = state_q.err;

endmodule

// File: rtl/ee_entry_chk.sv
module ee_entry_chk #(
    parameter int LVL_W  = 2,
    parameter int STAT_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              take_i,
    input logic              pc_we_o,
    input logic              link_we_o,
    input logic              sav_we_o,
    input logic              synd_we_o,
    input logic              fault_we_o,
    input logic              err_o,
    input logic [LVL_W-1:0]  lvl_o,
    input logic [STAT_W-1:0] status_o
);
    // R11
    pulse_after_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_we_o || err_o) |-> $past(take_i));

    // R10
    err_blocks_writes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !(pc_we_o || link_we_o || sav_we_o || synd_we_o || fault_we_o));

    // R4
    fault_needs_synd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_we_o |-> synd_we_o);

    // R7
    link_sav_together_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pc_we_o |-> (link_we_o && sav_we_o));

    // R9
    new_status_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pc_we_o |-> (status_o[9:6] == 4'hF && status_o[0] && status_o[2 +: LVL_W] == lvl_o));

    // R5
    synd_only_with_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        synd_we_o |-> pc_we_o);
endmodule

bind ee_entry_ctrl ee_entry_chk #(.LVL_W(LVL_W), .STAT_W(STAT_W)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take_i),
    .pc_we_o    (pc_we_o),
    .link_we_o  (link_we_o),
    .sav_we_o   (sav_we_o),
    .synd_we_o  (synd_we_o),
    .fault_we_o (fault_we_o),
    .err_o      (err_o),
    .lvl_o      (lvl_o),
    .status_o   (status_o)
);

// File: tb/test_ee_entry_ctrl.sv
module test_ee_entry_ctrl;
    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         take_i = 1'b0;
    logic [255:0] vbar_i;
    logic [1:0]   cur_lvl_i = '0, tgt_lvl_i = '0;
    logic         src64_i = 1'b1, sp_sel_i = 1'b0, thumb_i = 1'b0;
    logic [3:0]   exc_class_i = '0;
    logic [31:0]  syndrome_i = 32'h4400_1234;
    logic [63:0]  fault_addr_i = 64'hDEAD_BEEF_0000_1000;
    logic [63:0]  pc_i = 64'h0000_0000_0040_2000;
    logic [31:0]  status_i = 32'h6000_03C5;

    logic         pc_we_o, link_we_o, sav_we_o, synd_we_o, fault_we_o, err_o;
    logic [63:0]  pc_o, link_o, fault_o;
    logic [1:0]   lvl_o;
    logic [31:0]  sav_o, synd_o, status_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk_i = ~clk_i;

    ee_entry_ctrl i_ee_entry_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take_i), .vbar_i(vbar_i),
        .cur_lvl_i(cur_lvl_i), .tgt_lvl_i(tgt_lvl_i), .src64_i(src64_i),
        .sp_sel_i(sp_sel_i), .thumb_i(thumb_i), .exc_class_i(exc_class_i),
        .syndrome_i(syndrome_i), .fault_addr_i(fault_addr_i), .pc_i(pc_i),
        .status_i(status_i), .pc_we_o(pc_we_o), .pc_o(pc_o), .lvl_o(lvl_o),
        .link_we_o(link_we_o), .link_o(link_o), .sav_we_o(sav_we_o), .sav_o(sav_o),
        .synd_we_o(synd_we_o), .synd_o(synd_o), .fault_we_o(fault_we_o),
        .fault_o(fault_o), .status_o(status_o), .err_o(err_o)
    );

    function automatic logic [63:0] base_of(input logic [1:0] l);
        return 64'h0000_0040_0000_0800 + 64'(l) * 64'h0010_0000;
    endfunction

    initial begin
        for (int l = 0; l < 4; l++) vbar_i[l*64 +: 64] = base_of(2'(l));
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_take(input logic [3:0] cls, input logic [1:0] cur, input logic [1:0] tgt,
                           input logic s64, input logic sp, input logic th, input string req);
        logic [63:0] grp, kof, prev_pc;
        logic [31:0] esyn;
        logic        valid, ws, wf;
        @(negedge clk_i);
        prev_pc = pc_o;
        exc_class_i = cls; cur_lvl_i = cur; tgt_lvl_i = tgt;
        src64_i = s64; sp_sel_i = sp; thumb_i = th;
        pc_i = pc_i + 64'h40; status_i = status_i ^ 32'h0000_0011;
        fault_addr_i = fault_addr_i + 64'h8;
        take_i = 1'b1;
        valid = (cls < 4'd12);
        ws    = (cls < 4'd8);
        wf    = (cls < 4'd2);
        if (tgt > cur) grp = s64 ? 64'h400 : 64'h600;
        else           grp = sp ? 64'h200 : 64'h0;
        kof = (cls == 4'd8 || cls == 4'd9) ? 64'h80 :
              (cls == 4'd10 || cls == 4'd11) ? 64'h100 : 64'h0;
        esyn = syndrome_i;
        if (!s64 && !th) esyn[25] = 1'b1;
        @(posedge clk_i);
        #1;
        take_i = 1'b0;
        chk(64'(err_o), 64'(!valid), {req, " R10 err"});
        chk(64'(pc_we_o), 64'(valid), {req, " R11 pc_we"});
        if (valid) begin
            chk(pc_o, base_of(tgt) + grp + kof, {req, " R3 pc"});
            chk(64'(lvl_o), 64'(tgt), {req, " R7 lvl"});
            chk(64'(link_we_o), 64'd1, {req, " R7 link_we"});
            chk(link_o, pc_i, {req, " R7 link"});
            chk(64'(sav_we_o), 64'd1, {req, " R7 sav_we"});
            chk(64'(sav_o), 64'(status_i), {req, " R7 sav"});
            chk(64'(status_o), 64'(32'h3C1 | (32'(tgt) << 2)), {req, " R9 status"});
            chk(64'(synd_we_o), 64'(ws), {req, " R5 R6 synd_we"});
            if (ws) chk(64'(synd_o), 64'(esyn), {req, " R8 synd"});
            chk(64'(fault_we_o), 64'(wf), {req, " R4 R6 fault_we"});
            if (wf) chk(fault_o, fault_addr_i, {req, " R4 fault"});
        end else begin
            chk(64'({link_we_o, sav_we_o, synd_we_o, fault_we_o}), 64'd0, {req, " R10 no writes"});
            chk(pc_o, prev_pc, {req, " R10 pc held"});
        end
        @(posedge clk_i);
        #1;
        chk(64'({pc_we_o, link_we_o, sav_we_o, synd_we_o, fault_we_o, err_o}), 64'd0,
            {req, " R11 single pulse"});
    endtask

    task automatic t_reset();
        #1;
        chk(64'({pc_we_o, link_we_o, sav_we_o, synd_we_o, fault_we_o, err_o}), 64'd0, "R12 enables");
        chk(pc_o | link_o | fault_o, 64'd0, "R12 data");
        chk(64'(sav_o | synd_o | status_o), 64'd0, "R12 status");
    endtask

    task automatic t_level_rise();
        do_take(4'd4, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, "R1 rise from 64");
        do_take(4'd4, 2'd1, 2'd3, 1'b0, 1'b1, 1'b1, "R1 rise from 32");
    endtask

    task automatic t_same_level();
        do_take(4'd3, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0, "R2 same sp1");
        do_take(4'd3, 2'd2, 2'd2, 1'b1, 1'b0, 1'b0, "R2 same sp0");
    endtask

    task automatic t_kinds();
        do_take(4'd8,  2'd0, 2'd1, 1'b1, 1'b0, 1'b0, "R3 R6 irq");
        do_take(4'd9,  2'd1, 2'd1, 1'b1, 1'b1, 1'b0, "R3 R6 virq");
        do_take(4'd10, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, "R3 R6 fiq");
        do_take(4'd11, 2'd2, 2'd2, 1'b1, 1'b0, 1'b0, "R3 R6 vfiq");
    endtask

    task automatic t_sync_classes();
        for (int c = 0; c < 8; c++) do_take(4'(c), 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, "R4 R5 class sweep");
    endtask

    task automatic t_a32_syndrome();
        do_take(4'd3, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, "R8 a32 undef");
        do_take(4'd1, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, "R8 thumb abort");
        do_take(4'd1, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, "R8 a32 abort");
        do_take(4'd8, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, "R8 R6 a32 irq");
    endtask

    task automatic t_unsupported();
        for (int c = 12; c < 16; c++) do_take(4'(c), 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, "R10 bad class");
    endtask

    task automatic t_no_take();
        @(negedge clk_i);
        exc_class_i = 4'd1;
        repeat (3) @(posedge clk_i);
        #1;
        chk(64'({pc_we_o, link_we_o, sav_we_o, synd_we_o, fault_we_o, err_o}), 64'd0, "R11 idle");
    endtask

    initial begin
        t_reset();
        repeat (3) @(posedge clk_i);
        t_reset();
        @(negedge clk_i);
        rst_ni = 1'b1;
        t_level_rise();
        t_same_level();
        t_kinds();
        t_sync_classes();
        t_a32_syndrome();
        t_unsupported();
        t_no_take();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule